// File: doc/BRIEF.md
# Merged Propagate-Generate ALU

This block is an N-bit arithmetic and logic unit built around one ripple carry path. Each bit slice forms a propagate term and a generate term from its two operand bits. The result bit is the propagate term XOR the incoming carry. Addition, subtraction and every two-input bitwise function all go through the same path. Only the propagate function, the generate function and the carry-in change from one operation to the next. There is no operand inverter and no separate logic unit with an output multiplexer.

The propagate term comes from a 4-bit truth table, so any Boolean function of two bits is available. The generate term is chosen from three forms: A AND B, A AND NOT B, or constant zero. Logic operations force the generate term and the carry-in to zero, so every carry is zero and the result equals the propagate term. Subtraction uses propagate = A XNOR B, generate = A AND NOT B and carry-in = 1, which forms A plus the ones complement of B plus one.

An operation is presented with a valid strobe. Its result and carry-out are registered on that clock edge and appear with an output valid flag one cycle later.

Top module: `pg_alu_top`

## Requirements
- R1: While reset (rst_n low, asynchronous) is asserted and just after it, out_valid, result and carry_out are all zero.
- R2: out_valid equals in_valid as sampled at the previous rising clock edge. The result of an operation presented with in_valid high is visible on result and carry_out after that edge.
- R3: When in_valid is low at an edge, result and carry_out keep their previous values, whatever a, b, op and tt_raw are.
- R4: op 3'b000 (add): result = (a + b) mod 2^W, and carry_out = the carry out of bit W-1.
- R5: op 3'b001 (subtract): result = (a - b) mod 2^W, and carry_out = 1 exactly when a >= b as unsigned numbers (no borrow).
- R6: op 3'b010 gives a AND b, op 3'b011 gives a OR b, op 3'b100 gives a XOR b. For all three, carry_out is 0.
- R7: op 3'b101 (truth table): result bit i = tt_raw[3 - 2*a[i] - b[i]]. So tt_raw bit 3 gives the output for the input pair (0,0), bit 2 for (0,1), bit 1 for (1,0) and bit 0 for (1,1). With this order 4'b0001 is AND, 4'b0111 is OR and 4'b0110 is XOR. carry_out is 0.
- R8: op 3'b110 and 3'b111 are reserved. Both produce result 0 and carry_out 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| op | input | 3 | Operation code |
| tt_raw | input | 4 | Truth table used by op 3'b101 |
| a | input | W | First operand |
| b | input | W | Second operand |
| out_valid | output | 1 | Registered result is new |
| result | output | W | Registered result |
| carry_out | output | 1 | Registered carry-out; only meaningful for add and subtract |

## Verification
The assertions assume that op, a and b are stable and known at every edge where in_valid is high. They compare the registered outputs against the operands as captured with $past one cycle earlier. The bench changes inputs only on falling edges, so every strobed operation has fully settled operands at the rising edge. Hold behaviour is exercised by changing all inputs while the strobe is low, including to reserved codes.

// File: rtl/pg_alu_pkg.sv
package pg_alu_pkg;
    localparam logic [2:0] OP_ADD  = 3'b000;
    localparam logic [2:0] OP_SUB  = 3'b001;
    localparam logic [2:0] OP_AND  = 3'b010;
    localparam logic [2:0] OP_OR   = 3'b011;
    localparam logic [2:0] OP_XOR  = 3'b100;
    localparam logic [2:0] OP_TT   = 3'b101;

    // truth table bit 3 -> pair (0,0), bit 0 -> pair (1,1)
    localparam logic [3:0] TT_XOR  = 4'b0110;
    localparam logic [3:0] TT_XNOR = 4'b1001;
    localparam logic [3:0] TT_AND  = 4'b0001;
    localparam logic [3:0] TT_OR   = 4'b0111;
    localparam logic [3:0] TT_ZERO = 4'b0000;

    typedef enum logic [1:0] {
        GEN_ZERO  = 2'd0,
        GEN_AND   = 2'd1,
        GEN_ANDNB = 2'd2
    } gen_sel_e;

    typedef struct packed {
        logic [3:0] ptab;
        gen_sel_e   gsel;
        logic       cin;
    } pg_ctrl_t;
endpackage

// File: rtl/pg_op_decode.sv
module pg_op_decode
    import pg_alu_pkg::*;
(
    input  logic [2:0] op,
    input  logic [3:0] tt_raw,
    output pg_ctrl_t   ctrl
);
    always_comb begin
        ctrl = '{ptab: TT_ZERO, gsel: GEN_ZERO, cin: 1'b0};
        case (op)
            OP_ADD: ctrl = '{ptab: TT_XOR,  gsel: GEN_AND,   cin: 1'b0};
            OP_SUB: ctrl = '{ptab: TT_XNOR, gsel: GEN_ANDNB, cin: 1'b1};
            OP_AND: ctrl.ptab = TT_AND;
            OP_OR:  ctrl.ptab = TT_OR;
            OP_XOR: ctrl.ptab = TT_XOR;
            OP_TT:  ctrl.ptab = tt_raw;
            default: ctrl.ptab = TT_ZERO;
        endcase
    end
endmodule

// File: rtl/pg_slice_array.sv
module pg_slice_array
    import pg_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  pg_ctrl_t     ctrl,
    output logic [W-1:0] prop,
    output logic [W-1:0] gen
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] pair;
        assign pair = {a[i], b[i]};
        // table index counts down from the (0,0) entry at bit 3
        assign prop[i] = ctrl.ptab[2'd3 - pair];
        always_comb begin
            case (ctrl.gsel)
                GEN_AND:   gen[i] = a[i] & b[i];
                GEN_ANDNB: gen[i] = a[i] & ~b[i];
                default:   gen[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pg_carry_chain.sv
module pg_carry_chain #(
    parameter int W = 8
) (
    input  logic [W-1:0] prop,
    input  logic [W-1:0] gen,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] c;
    assign c[0] = cin;
    for (genvar i = 0; i < W; i++) begin : g_stage
        assign c[i+1] = gen[i] | (prop[i] & c[i]);
        assign sum[i] = prop[i] ^ c[i];
    end
    assign cout = c[W];
endmodule

// File: rtl/pg_alu_top.sv
module pg_alu_top
    import pg_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [2:0]   op,
    input  logic [3:0]   tt_raw,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic         carry_out
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
        logic         cy;
    } out_state_t;

    pg_ctrl_t     ctrl;
    logic [W-1:0] prop, gen, sum;
    logic         cout;
    out_state_t   st_d, st_q;

    pg_op_decode u_dec (.op(op), .tt_raw(tt_raw), .ctrl(ctrl));

    pg_slice_array #(.W(W)) u_pg (
        .a(a), .b(b), .ctrl(ctrl), .prop(prop), .gen(gen)
    );

    pg_carry_chain #(.W(W)) u_cc (
        .prop(prop), .gen(gen), .cin(ctrl.cin), .sum(sum), .cout(cout)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = sum;
            st_d.cy  = cout;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign carry_out = st_q.cy;

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(carry_out)));
    p_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_ADD) |=>
        ({carry_out, result} == ({1'b0, $past(a)} + {1'b0, $past(b)})));
    p_sub_borrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_SUB) |=> (carry_out == ($past(a) >= $past(b))));
    p_logic_nocarry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=> !carry_out);
    p_and_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_AND) |=> (result == ($past(a) & $past(b))));
    p_tt_nocarry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_TT) |=> !carry_out);
    p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[2:1] == 2'b11) |=> (result == '0 && !carry_out));
endmodule

// File: tb/tb_pg_alu_top.sv
module tb_pg_alu_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [2:0]   op = '0;
    logic [3:0]   tt_raw = '0;
    logic [W-1:0] a = '0, b = '0;
    logic         out_valid, carry_out;
    logic [W-1:0] result;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    pg_alu_top #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .tt_raw(tt_raw),
        .a(a), .b(b), .out_valid(out_valid), .result(result), .carry_out(carry_out)
    );

    // {op, tt, a, b, expected result, expected carry}
    localparam int NV = 16;
    localparam logic [31:0] VEC [NV] = '{
        {3'd0, 4'h0, 8'h00, 8'h00, 8'h00, 1'b0},  // R4
        {3'd0, 4'h0, 8'hFF, 8'h01, 8'h00, 1'b1},  // R4
        {3'd0, 4'h0, 8'h7F, 8'h01, 8'h80, 1'b0},  // R4
        {3'd0, 4'h0, 8'hC8, 8'h64, 8'h2C, 1'b1},  // R4
        {3'd1, 4'h0, 8'h05, 8'h03, 8'h02, 1'b1},  // R5
        {3'd1, 4'h0, 8'h03, 8'h05, 8'hFE, 1'b0},  // R5
        {3'd1, 4'h0, 8'h00, 8'h00, 8'h00, 1'b1},  // R5
        {3'd1, 4'h0, 8'h80, 8'h01, 8'h7F, 1'b1},  // R5
        {3'd2, 4'h0, 8'hF0, 8'h3C, 8'h30, 1'b0},  // R6
        {3'd3, 4'h0, 8'hF0, 8'h3C, 8'hFC, 1'b0},  // R6
        {3'd4, 4'h0, 8'hF0, 8'h3C, 8'hCC, 1'b0},  // R6
        {3'd5, 4'h9, 8'hF0, 8'h3C, 8'h33, 1'b0},  // R7 xnor
        {3'd5, 4'hC, 8'hF0, 8'h3C, 8'h0F, 1'b0},  // R7 not a
        {3'd5, 4'h5, 8'hF0, 8'h3C, 8'h3C, 1'b0},  // R7 pass b
        {3'd6, 4'hF, 8'hF0, 8'h3C, 8'h00, 1'b0},  // R8
        {3'd7, 4'hF, 8'hFF, 8'hFF, 8'h00, 1'b0}   // R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model(input logic [2:0] o, input logic [3:0] t,
                         input logic [W-1:0] x, input logic [W-1:0] y,
                         output logic [W-1:0] r, output logic c);
        c = 1'b0;
        r = '0;
        case (o)
            3'd0: {c, r} = {1'b0, x} + {1'b0, y};
            3'd1: begin r = x - y; c = (x >= y); end
            3'd2: r = x & y;
            3'd3: r = x | y;
            3'd4: r = x ^ y;
            3'd5: for (int i = 0; i < W; i++) r[i] = t[3 - 2*int'(x[i]) - int'(y[i])];
            default: r = '0;
        endcase
    endtask

    task automatic issue(input logic [2:0] o, input logic [3:0] t,
                         input logic [W-1:0] x, input logic [W-1:0] y);
        @(negedge clk);
        in_valid = 1'b1; op = o; tt_raw = t; a = x; b = y;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic string req_of(input logic [2:0] o);
        case (o)
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2, 3'd3, 3'd4: return "R6";
            3'd5: return "R7";
            default: return "R8";
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid", 32'(out_valid), 0);
        check("R1 result", 32'(result), 0);
        check("R1 carry", 32'(carry_out), 0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            logic [31:0] v;
            v = VEC[k];
            issue(v[31:29], v[28:25], v[24:17], v[16:9]);
            check("R2 valid", 32'(out_valid), 1);
            check({req_of(v[31:29]), " result"}, 32'(result), 32'(v[8:1]));
            check({req_of(v[31:29]), " carry"}, 32'(carry_out), 32'(v[0]));
        end

        // R3: inputs churn with strobe low
        issue(3'd0, 4'h0, 8'hFF, 8'hFF);
        in_valid = 1'b0; op = 3'd1; a = 8'h12; b = 8'h34; tt_raw = 4'hF;
        @(negedge clk);
        check("R2 drop", 32'(out_valid), 0);
        check("R3 result", 32'(result), 32'h FE);
        check("R3 carry", 32'(carry_out), 1);
        op = 3'd7; a = 8'h00;
        @(negedge clk);
        check("R3 result2", 32'(result), 32'hFE);

        // back-to-back strobes
        @(negedge clk);
        in_valid = 1'b1; op = 3'd0; a = 8'h10; b = 8'h20;
        @(negedge clk);
        check("R2 b2b first", 32'(result), 32'h30);
        op = 3'd1; a = 8'h10; b = 8'h20;
        @(negedge clk);
        in_valid = 1'b0;
        check("R5 b2b second", 32'(result), 32'hF0);
        check("R5 b2b borrow", 32'(carry_out), 0);

        // random sweep over all opcodes
        for (int k = 0; k < 800; k++) begin
            logic [2:0] o; logic [3:0] t; logic [W-1:0] x, y, er; logic ec;
            o = 3'(k % 8); t = 4'($urandom); x = W'($urandom); y = W'($urandom);
            if (k % 50 == 0) x = '1;
            if (k % 70 == 0) y = '0;
            model(o, t, x, y, er, ec);
            issue(o, t, x, y);
            check({req_of(o), " rnd result"}, 32'(result), 32'(er));
            check({req_of(o), " rnd carry"}, 32'(carry_out), 32'(ec));
        end

        // R1: asynchronous reset mid-run
        issue(3'd0, 4'h0, 8'h01, 8'h01);
        #3 rst_n = 1'b0;
        #2;
        check("R1 async valid", 32'(out_valid), 0);
        check("R1 async result", 32'(result), 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule